// File: doc/BRIEF.md
# Colour-Tagged Fetch Stream Filter

This block sits between an instruction prefetch queue and an execute stage. Both sides use valid/ready handshakes. Each prefetched word arrives with its own program-counter value and a one-bit stream colour. The block keeps the colour of the stream that is currently live. A word that carries any other colour is accepted and thrown away, so no flush signal has to reach back into the prefetch pipeline.

When the execute stage resolves a taken branch, it pulses `br_take` with the target address. The block then inverts its live colour and raises a redirect request toward the fetch unit. The request carries the target and the new colour, and it stays up until the fetch unit accepts it. The fetch unit copies the colour of its most recent redirect onto every word it emits. Words from the old stream are dropped until words with the new colour start to arrive.

The redirect channel is separate from the word path, and stale words are always accepted. A branch therefore cannot deadlock against a full prefetch queue.

Top module: `clr_stream_filter`

## Requirements
- R1: After reset the live colour is 0, `out_valid` is low, and one redirect is pending with `req_pc` equal to the `RESET_VEC` parameter and `req_colour` equal to 0.
- R2: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_pc` and `req_colour` keep their values into the next cycle.
- R3: A `br_take` pulse while no redirect is pending inverts the live colour. In the next cycle `req_valid` is high, `req_pc` equals `br_target` and `req_colour` equals the inverted colour.
- R4: A `br_take` pulse while a redirect is still pending is ignored. The live colour, `req_pc` and `req_colour` are unchanged.
- R5: A word whose colour equals the live colour is accepted when the output slot is free. It appears on `out_insn`/`out_pc` with `out_valid` high in the cycle after acceptance, and words leave in arrival order.
- R6: A word whose colour differs from the live colour always sees `in_ready` high, whatever the state of `out_ready`. It never produces an output beat.
- R7: A word that arrives in the same cycle as an accepted branch and carries the old colour is dropped.
- R8: A word waiting in the output slot that has not been taken by the end of an accepted branch cycle is withdrawn. `out_valid` is low in the next cycle unless a new-colour word was loaded in that same cycle.
- R9: While `out_valid` is high and `out_ready` is low, and no branch is accepted, `out_valid`, `out_insn` and `out_pc` stay stable.
- R10: A word with the live colour sees `in_ready` low exactly when the output slot holds a live word and `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Prefetched word valid |
| in_ready | output | 1 | Word accepted (kept or dropped) |
| in_insn | input | 32 | Prefetched instruction word |
| in_pc | input | 32 | Program counter of the word |
| in_colour | input | 1 | Stream colour of the word |
| out_valid | output | 1 | Word offered to execute |
| out_ready | input | 1 | Execute takes the word |
| out_insn | output | 32 | Instruction word to execute |
| out_pc | output | 32 | Program counter travelling with it |
| br_take | input | 1 | Taken branch resolved this cycle |
| br_target | input | 32 | Branch target address |
| req_valid | output | 1 | Redirect request pending |
| req_ready | input | 1 | Fetch unit accepts the redirect |
| req_pc | output | 32 | Address to fetch from |
| req_colour | output | 1 | Colour the new stream will carry |

## Verification
A wrong live colour does not stay hidden for long. It shows within one cycle as a flipped `in_ready` decision, and at the latest one cycle later as a dropped or extra beat on the output side. It also shows on `req_colour` at the next redirect.

A stale word left in the output slot shows up as `out_valid` staying high in the cycle after a branch. A request register that loses its contents shows up as a changed `req_pc` while the fetch side holds `req_ready` low.

A reference model of colour, slot and request, driven by mixed random and directed stimulus, therefore finds most such faults within a cycle or two of the event that causes them.

// File: rtl/clr_pkg.sv
package clr_pkg;

    parameter int unsigned PC_W   = 32;
    parameter int unsigned INSN_W = 32;

    typedef logic colour_t;

    typedef struct packed {
        logic [INSN_W-1:0] insn;
        logic [PC_W-1:0]   pc;
        colour_t           colour;
    } tagged_word_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        colour_t         colour;
    } redirect_t;

    function automatic colour_t next_colour(colour_t cur, logic flip);
        return flip ? ~cur : cur;
    endfunction

endpackage

// File: rtl/clr_colour_ctrl.sv
module clr_colour_ctrl
    import clr_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_VEC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            br_take,
    input  logic [PC_W-1:0] br_target,
    input  logic            req_ready,
    output colour_t         colour_q,
    output colour_t         colour_nxt,
    output logic            req_valid,
    output redirect_t       req
);

    logic accept;

    assign accept     = br_take && !req_valid;
    assign colour_nxt = next_colour(colour_q, accept);

    always_ff @(posedge clk) begin
        if (rst) begin
            colour_q  <= 1'b0;
            req_valid <= 1'b1;
            req       <= '{pc: RESET_VEC, colour: 1'b0};
        end else begin
            colour_q <= colour_nxt;
            if (accept) begin
                req_valid <= 1'b1;
                req       <= '{pc: br_target, colour: colour_nxt};
            end else if (req_valid && req_ready) begin
                req_valid <= 1'b0;
            end
        end
    end

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req.pc) && $stable(req.colour));

    p_redirect_r3: assert property (@(posedge clk) disable iff (rst)
        br_take && !req_valid |=> req_valid && req.pc == $past(br_target)
                                  && req.colour != $past(colour_q));

    p_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        br_take && req_valid && !req_ready |=> $stable(colour_q) && $stable(req.pc));

endmodule

// File: rtl/clr_tag_filter.sv
module clr_tag_filter
    import clr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  colour_t      colour_q,
    input  colour_t      colour_nxt,
    input  logic         in_valid,
    input  tagged_word_t in_word,
    output logic         in_ready,
    output logic         out_valid,
    input  logic         out_ready,
    output tagged_word_t out_word
);

    tagged_word_t held_q;
    logic         held_v;
    logic         live;
    logic         slot_free;
    logic         stale_in;
    logic         keep;

    assign live      = held_v && (held_q.colour == colour_q);
    assign slot_free = !live || out_ready;
    assign stale_in  = in_word.colour != colour_nxt;
    assign keep      = in_valid && !stale_in && slot_free;
    assign in_ready  = slot_free || stale_in;
    assign out_valid = live;
    assign out_word  = held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_v <= 1'b0;
            held_q <= '0;
        end else if (keep) begin
            held_v <= 1'b1;
            held_q <= in_word;
        end else if ((live && out_ready) || held_q.colour != colour_nxt) begin
            held_v <= 1'b0;
        end
    end

    p_stale_ready_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && stale_in |-> in_ready);

    p_withdraw_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && colour_nxt != colour_q && !keep |=> !out_valid);

    p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && colour_nxt == colour_q
        |=> out_valid && $stable(out_word.pc) && $stable(out_word.insn));

    p_backpressure_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && in_valid && !stale_in |-> !in_ready);

endmodule

// File: rtl/clr_stream_filter.sv
module clr_stream_filter
    import clr_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [PC_W-1:0]   in_pc,
    input  logic              in_colour,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [INSN_W-1:0] out_insn,
    output logic [PC_W-1:0]   out_pc,
    input  logic              br_take,
    input  logic [PC_W-1:0]   br_target,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [PC_W-1:0]   req_pc,
    output logic              req_colour
);

    colour_t      colour_q;
    colour_t      colour_nxt;
    redirect_t    req;
    tagged_word_t in_word;
    tagged_word_t out_word;

    assign in_word    = '{insn: in_insn, pc: in_pc, colour: in_colour};
    assign out_insn   = out_word.insn;
    assign out_pc     = out_word.pc;
    assign req_pc     = req.pc;
    assign req_colour = req.colour;

    clr_colour_ctrl #(.RESET_VEC(RESET_VEC)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .br_take    (br_take),
        .br_target  (br_target),
        .req_ready  (req_ready),
        .colour_q   (colour_q),
        .colour_nxt (colour_nxt),
        .req_valid  (req_valid),
        .req        (req)
    );

    clr_tag_filter u_filt (
        .clk        (clk),
        .rst        (rst),
        .colour_q   (colour_q),
        .colour_nxt (colour_nxt),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_word   (out_word)
    );

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) && !rst |-> req_valid && req_pc == RESET_VEC && !req_colour && !out_valid);

endmodule

// File: tb/clr_stream_filter_bench.sv
module clr_stream_filter_bench;

    localparam logic [31:0] RV = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 0, in_colour = 0, out_ready = 0, br_take = 0, req_ready = 0;
    logic [31:0] in_insn = 0, in_pc = 0, br_target = 0;
    logic        in_ready, out_valid, req_valid, req_colour;
    logic [31:0] out_insn, out_pc, req_pc;

    // staged stimulus
    logic        s_iv, s_ic, s_ordy, s_bt, s_rrdy;
    logic [31:0] s_insn, s_pc, s_tgt;

    // reference model
    logic        m_col, m_sv, m_rv, m_rc;
    logic [31:0] m_si, m_sp, m_rp;

    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    clr_stream_filter #(.RESET_VEC(RV)) u_clr_stream_filter (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn), .in_pc(in_pc),
        .in_colour(in_colour),
        .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn), .out_pc(out_pc),
        .br_take(br_take), .br_target(br_target),
        .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc), .req_colour(req_colour)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_ready(logic ic, logic ncol, logic sv, logic ordy);
        return (!sv || ordy) || (ic != ncol);
    endfunction

    task automatic cycle();
        logic acc, ncol, free, keep;
        @(negedge clk);
        in_valid = s_iv; in_insn = s_insn; in_pc = s_pc; in_colour = s_ic;
        out_ready = s_ordy; br_take = s_bt; br_target = s_tgt; req_ready = s_rrdy;
        #1;
        acc  = s_bt && !m_rv;
        ncol = acc ? ~m_col : m_col;
        free = !m_sv || s_ordy;
        chk(out_valid == m_sv, "R5 out_valid", out_valid, m_sv);
        if (m_sv) begin
            chk(out_pc == m_sp, "R5 out_pc", out_pc, m_sp);
            chk(out_insn == m_si, "R5 out_insn", out_insn, m_si);
        end
        chk(req_valid == m_rv, "R3 req_valid", req_valid, m_rv);
        if (m_rv) begin
            chk(req_pc == m_rp, "R2 req_pc", req_pc, m_rp);
            chk(req_colour == m_rc, "R2 req_colour", req_colour, m_rc);
        end
        if (s_ic != ncol)
            chk(in_ready == 1'b1, "R6 stale in_ready", in_ready, 1);
        else
            chk(in_ready == exp_ready(s_ic, ncol, m_sv, s_ordy), "R10 in_ready", in_ready,
                exp_ready(s_ic, ncol, m_sv, s_ordy));
        keep = s_iv && (s_ic == ncol) && free;
        if (keep) begin
            m_sv = 1; m_si = s_insn; m_sp = s_pc;
        end else if ((m_sv && s_ordy) || acc) begin
            m_sv = 0;
        end
        if (acc) begin
            m_rv = 1; m_rp = s_tgt; m_rc = ncol;
        end else if (m_rv && s_rrdy) begin
            m_rv = 0;
        end
        m_col = ncol;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        s_iv = 0; s_ic = 0; s_ordy = 0; s_bt = 0; s_rrdy = 0;
        s_insn = 0; s_pc = 0; s_tgt = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] fpc;
        void'($urandom(32'h5eed_1234));
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(req_valid == 1, "R1 req_valid", req_valid, 1);
        chk(req_pc == RV, "R1 req_pc", req_pc, RV);
        chk(req_colour == 0, "R1 req_colour", req_colour, 0);
        m_col = 0; m_sv = 0; m_rv = 1; m_rp = RV; m_rc = 0; m_si = 0; m_sp = 0;

        // R4: branch while the reset redirect is still pending
        idle(); s_bt = 1; s_tgt = 32'h2000;
        cycle();
        chk(req_pc == RV, "R4 req_pc", req_pc, RV);
        chk(req_colour == 0, "R4 req_colour", req_colour, 0);

        // R2: redirect held, then taken
        idle(); cycle();
        idle(); s_rrdy = 1; cycle();
        chk(req_valid == 0, "R2 req taken", req_valid, 0);

        // R5/R10: fill slot under backpressure
        idle(); s_iv = 1; s_ic = 0; s_pc = RV; s_insn = 32'hA0; cycle();
        chk(out_valid && out_pc == RV, "R5 first word", out_pc, RV);
        idle(); s_iv = 1; s_ic = 0; s_pc = RV + 4; s_insn = 32'hA1; cycle();
        // R9: held under out_ready low
        idle(); cycle();
        chk(out_valid && out_pc == RV && out_insn == 32'hA0, "R9 hold", out_pc, RV);
        // R6: stale word while slot full and blocked
        idle(); s_iv = 1; s_ic = 1; s_pc = 32'hDEAD0; cycle();
        chk(out_pc == RV, "R6 no effect", out_pc, RV);

        // R8 + R7: branch with a blocked slot and an old-colour word arriving
        idle(); s_bt = 1; s_tgt = 32'h3000; s_iv = 1; s_ic = 0; s_pc = RV + 4; s_insn = 32'hA1;
        cycle();
        chk(out_valid == 0, "R8 withdrawn", out_valid, 0);
        chk(req_pc == 32'h3000 && req_colour == 1, "R3 redirect", req_pc, 32'h3000);
        idle(); s_iv = 1; s_ic = 0; s_pc = RV + 8; s_ordy = 1; cycle();
        chk(out_valid == 0, "R7 old colour dropped", out_valid, 0);
        idle(); s_rrdy = 1; s_iv = 1; s_ic = 1; s_pc = 32'h3000; s_insn = 32'hB0; s_ordy = 1;
        cycle();
        chk(out_valid && out_pc == 32'h3000, "R5 new stream", out_pc, 32'h3000);

        // constrained random
        fpc = 32'h3004;
        for (int i = 0; i < 4000; i++) begin
            s_iv   = ($urandom % 4) != 0;
            s_ic   = (($urandom % 5) == 0) ? ~m_col : m_col;
            s_pc   = fpc;
            s_insn = $urandom;
            s_ordy = ($urandom % 3) != 0;
            s_rrdy = $urandom % 2;
            s_bt   = ($urandom % 20) == 0;
            s_tgt  = {$urandom % 32'h10000, 2'b00};
            cycle();
            fpc = fpc + 4;
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule